// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small CPU core and decides which peripheral request, if any, the core should service next. Each source has its own enable bit, and one global enable gates them all. A source is built either as an event source, whose rising edge latches a pending flag, or as a level source, which requests only while its line is high and keeps no flag. The choice is made per source by a parameter mask. Among the enabled requests, the lowest source index wins. The controller turns the winner into a vector address and holds it with a valid signal until the core acknowledges it.

The block also enforces when an interrupt may be taken. A request is accepted only at an instruction boundary, reported by the core through `instr_done`. After a return-from-interrupt, or after the instruction that sets the global enable, exactly one more instruction completes before any request is accepted. The instruction that clears the global enable blocks acceptance in the same cycle.

Vector slot 0 belongs to reset. Source k uses slot k+1, and each slot is two words wide. A select input moves the table base from 0 to a boot base address. The stack and the CPU datapath are not part of this block.

Top module: `irqc_top`

## Requirements
- R1: While reset is asserted, and after it is released, `vec_valid` is 0, `gie` is 0, and `enables` and `flags` are all zero. Reset is asynchronous.
- R2: A rising edge on an event source's line sets its bit in `flags` at the next clock edge. This happens even when that source's enable or the global enable is 0. The flag stays set, and nothing is vectored while `gie` is 0.
- R3: When `clr_we` is 1, each 1 bit of `clr_data` clears the matching flag, and each 0 bit leaves its flag unchanged. A new event in the same cycle as its clear leaves the flag set.
- R4: A level source (bit set in LEVEL_MASK; by default sources 6 and 7) never shows a flag. It requests only while its line is high, and a pulse that ends while the source is disabled is forgotten.
- R5: An interrupt is taken at a clock edge only when all of the following hold: `instr_done` is 1, `gie` is 1, the source is enabled and requesting, no one-instruction hold is pending, and no vector is outstanding. When several sources qualify, the lowest index wins.
- R6: The vector address is the base plus 2×(index+1). The base is 0 when `vsel` is 0 and BOOT_BASE (default 0xC00) when `vsel` is 1. `vec_src` gives the index.
- R7: Taking an interrupt sets `vec_valid`, clears `gie`, and clears the winner's event flag. `vec_valid` and `vec_addr` then hold until the edge at which `int_ack` is 1, and `vec_valid` is 0 after that edge.
- R8: `reti` sets `gie`. The next boundary after it takes no interrupt, and the boundary after that one may take an interrupt.
- R9: `gie_set` sets `gie`, with the same one-instruction hold as R8.
- R10: `gie_clr` clears `gie`, and no interrupt is taken at the edge where it is 1, even when a request and `instr_done` are present at that edge. It has priority over `gie_set` and `reti`.
- R11: `en_we` loads `en_wdata` into `enables`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N | Request lines, one per source |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | N | New enable bits |
| clr_we | input | 1 | Write strobe for flag clearing |
| clr_data | input | N | Ones select the flags to clear |
| vsel | input | 1 | Vector table base select |
| gie_set | input | 1 | Instruction that sets global enable completes |
| gie_clr | input | 1 | Instruction that clears global enable completes |
| instr_done | input | 1 | Instruction boundary |
| reti | input | 1 | Return-from-interrupt completes |
| int_ack | input | 1 | Core accepts the presented vector |
| vec_valid | output | 1 | Vector outstanding |
| vec_addr | output | AW | Vector address |
| vec_src | output | IW | Index of the vectored source |
| gie | output | 1 | Global enable state |
| flags | output | N | Pending flags |
| enables | output | N | Enable register |

## Verification
On every cycle, the assertions check the following:
- the grant is one-hot and agrees with the encoded index;
- level sources never hold a flag;
- no take happens during the hold after `reti` or `gie_set`, or in a cycle with `gie_clr`;
- every new vector follows a boundary taken with `gie` set;
- an unacknowledged vector stays stable;
- `gie` is 0 after each take.

Only the bench scenarios can show the rest:
- the priority order and the address arithmetic across mixed enable patterns;
- which flag a take clears;
- that a short level pulse is forgotten;
- that a clear write of zeros has no effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Slot k+1 belongs to source k; each slot spans two words.
  function automatic logic [31:0] slot_addr(input logic [31:0] base,
                                            input int unsigned idx);
    return base + 32'((idx + 1) * 2);
  endfunction

  // Index of the lowest set bit (0 when none is set).
  function automatic int unsigned lowest_set(input logic [63:0] v);
    int unsigned r;
    logic hit;
    r   = 0;
    hit = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (v[i] && !hit) begin
        r   = i;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/irqc_flags.sv
module irqc_flags #(
  parameter int N = 8,
  parameter logic [N-1:0] LEVEL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_i,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  input  logic [N-1:0] svc_clr,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] irq_q;
  logic [N-1:0] flag_q;
  logic [N-1:0] clr_mask;
  logic [N-1:0] flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_i;
  end

  // Rising edges on event sources only.
  assign evt_o    = irq_i & ~irq_q & ~LEVEL_MASK;
  assign clr_mask = (clr_we ? clr_data : '0) | svc_clr;
  // A fresh event wins over any clear in the same cycle.
  assign flag_d   = (evt_o | (flag_q & ~clr_mask)) & ~LEVEL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags_o = flag_q;

  // R4: level sources keep no flag
  a_r4_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & LEVEL_MASK) == '0);

  // R2: an event always leaves its flag set
  a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o != '0) |=> ((flag_q & $past(evt_o)) == $past(evt_o)));
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  import irqc_pkg::*;

  logic [N-1:0] lower;

  // Ripple chain: lower[g] is set if any source below g is requesting.
  for (genvar g = 0; g < N; g++) begin : g_chain
    if (g == 0) begin : g_first
      assign lower[g] = 1'b0;
    end else begin : g_rest
      assign lower[g] = lower[g-1] | req[g-1];
    end
  end

  assign grant = req & ~lower;
  assign any   = |req;
  assign idx   = IW'(lowest_set(64'(req)));

  // R5: a single winner, and it matches the encoded index
  a_r5_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));

  a_r5_index_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> grant[idx]);
endmodule

// File: rtl/irqc_seq.sv
module irqc_seq #(
  parameter int N  = 8,
  parameter int AW = 12,
  parameter int IW = $clog2(N),
  parameter logic [AW-1:0] BOOT_BASE = AW'(12'hC00)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_req,
  input  logic [IW-1:0] idx,
  input  logic          vsel,
  input  logic          instr_done,
  input  logic          gie_set,
  input  logic          gie_clr,
  input  logic          reti,
  input  logic          int_ack,
  output logic          take_o,
  output logic          gie_o,
  output logic          vec_valid_o,
  output logic [AW-1:0] vec_addr_o,
  output logic [IW-1:0] vec_src_o
);
  import irqc_pkg::*;

  logic          gie_q;
  logic          hold_q;
  logic          vld_q;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] src_q;
  logic          arm_evt;
  logic          take;

  // Instructions that re-enable interrupts open a one-instruction hold.
  assign arm_evt = gie_set | reti;
  assign take    = instr_done & any_req & gie_q & ~hold_q & ~vld_q
                 & ~gie_clr & ~arm_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (gie_clr)      gie_q <= 1'b0;
      else if (take)    gie_q <= 1'b0;
      else if (arm_evt) gie_q <= 1'b1;

      if (arm_evt)         hold_q <= 1'b1;
      else if (instr_done) hold_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      src_q  <= '0;
    end else if (take) begin
      vld_q  <= 1'b1;
      addr_q <= AW'(slot_addr(vsel ? 32'(BOOT_BASE) : 32'd0, 32'(idx)));
      src_q  <= idx;
    end else if (int_ack) begin
      vld_q  <= 1'b0;
    end
  end

  assign take_o      = take;
  assign gie_o       = gie_q;
  assign vec_valid_o = vld_q;
  assign vec_addr_o  = addr_q;
  assign vec_src_o   = src_q;

  // R10: disabling blocks a take in the same cycle
  a_r10_clr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |-> !take);

  // R8: no take during the hold after reti or gie_set
  a_r8_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !take);

  // R7: a take leaves the global enable cleared
  a_r7_take_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie_q);

  // R7: an unacknowledged vector holds
  a_r7_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !int_ack) |=> (vld_q && $stable(addr_q) && $stable(src_q)));

  // R5: a new vector follows a boundary with the global enable set
  a_r5_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(instr_done && gie_q));
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int N  = 8,
  parameter int AW = 12,
  parameter int IW = $clog2(N),
  parameter logic [N-1:0]  LEVEL_MASK = N'(8'hC0),
  parameter logic [AW-1:0] BOOT_BASE  = AW'(12'hC00)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_i,
  input  logic          en_we,
  input  logic [N-1:0]  en_wdata,
  input  logic          clr_we,
  input  logic [N-1:0]  clr_data,
  input  logic          vsel,
  input  logic          gie_set,
  input  logic          gie_clr,
  input  logic          instr_done,
  input  logic          reti,
  input  logic          int_ack,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr,
  output logic [IW-1:0] vec_src,
  output logic          gie,
  output logic [N-1:0]  flags,
  output logic [N-1:0]  enables
);
  logic [N-1:0]  en_q;
  logic [N-1:0]  flag_w;
  logic [N-1:0]  evt_w;
  logic [N-1:0]  req_w;
  logic [N-1:0]  grant_w;
  logic [N-1:0]  svc_clr_w;
  logic [IW-1:0] idx_w;
  logic          any_w;
  logic          take_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  irqc_flags #(.N(N), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
    .clr_we(clr_we), .clr_data(clr_data), .svc_clr(svc_clr_w),
    .flags_o(flag_w), .evt_o(evt_w)
  );

  // Level sources request straight from the line; events via flags.
  assign req_w = en_q & (flag_w | (irq_i & LEVEL_MASK));

  irqc_pick #(.N(N), .IW(IW)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(req_w),
    .grant(grant_w), .idx(idx_w), .any(any_w)
  );

  irqc_seq #(.N(N), .AW(AW), .IW(IW), .BOOT_BASE(BOOT_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .any_req(any_w), .idx(idx_w), .vsel(vsel),
    .instr_done(instr_done), .gie_set(gie_set), .gie_clr(gie_clr),
    .reti(reti), .int_ack(int_ack), .take_o(take_w), .gie_o(gie),
    .vec_valid_o(vec_valid), .vec_addr_o(vec_addr), .vec_src_o(vec_src)
  );

  assign svc_clr_w = take_w ? grant_w : '0;
  assign flags     = flag_w;
  assign enables   = en_q;

  // R7: a take clears only the winner's flag, unless it re-fires
  a_r7_clear_winner: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> ((flag_w & $past(grant_w & ~LEVEL_MASK & ~evt_w)) == '0));
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 12;
  localparam int IW = 3;
  localparam int BOOT = 'hC00;

  // {pattern[19:12], enable[11:4], vsel[3], winner[2:0]}
  localparam logic [19:0] TBL [0:5] = '{
    {8'h01, 8'hFF, 1'b0, 3'd0},
    {8'h0A, 8'hFF, 1'b0, 3'd1},
    {8'h0A, 8'hFD, 1'b0, 3'd3},
    {8'h30, 8'hFF, 1'b1, 3'd4},
    {8'h24, 8'h20, 1'b1, 3'd5},
    {8'h3F, 8'hFE, 1'b0, 3'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_i = '0;
  logic          en_we = 1'b0;
  logic [N-1:0]  en_wdata = '0;
  logic          clr_we = 1'b0;
  logic [N-1:0]  clr_data = '0;
  logic          vsel = 1'b0;
  logic          gie_set = 1'b0;
  logic          gie_clr = 1'b0;
  logic          instr_done = 1'b0;
  logic          reti = 1'b0;
  logic          int_ack = 1'b0;
  logic          vec_valid;
  logic [AW-1:0] vec_addr;
  logic [IW-1:0] vec_src;
  logic          gie;
  logic [N-1:0]  flags;
  logic [N-1:0]  enables;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .en_we(en_we),
    .en_wdata(en_wdata), .clr_we(clr_we), .clr_data(clr_data),
    .vsel(vsel), .gie_set(gie_set), .gie_clr(gie_clr),
    .instr_done(instr_done), .reti(reti), .int_ack(int_ack),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_src(vec_src),
    .gie(gie), .flags(flags), .enables(enables)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock edge; strobes last for exactly that edge.
  task automatic step();
    @(posedge clk);
    #1;
    en_we = 0; clr_we = 0; gie_set = 0; gie_clr = 0;
    instr_done = 0; reti = 0; int_ack = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    irq_i = '0;
    #(CLK_PERIOD * 2);
    rst_n = 1;
    step();
  endtask

  task automatic write_en(input logic [N-1:0] v);
    en_wdata = v; en_we = 1; step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, asynchronously while asserted and after release
    #(CLK_PERIOD + 2);
    check("R1 valid in reset", 32'(vec_valid), 0);
    check("R1 gie in reset", 32'(gie), 0);
    do_reset();
    check("R1 flags", 32'(flags), 0);
    check("R1 enables", 32'(enables), 0);
    check("R1 valid", 32'(vec_valid), 0);

    // Table: priority and address over enable patterns
    for (int i = 0; i < 6; i++) begin
      logic [7:0] pat, en;
      logic vs;
      int w, exp_addr;
      pat = TBL[i][19:12]; en = TBL[i][11:4]; vs = TBL[i][3]; w = TBL[i][2:0];
      exp_addr = (vs ? BOOT : 0) + 2 * w + 2;
      vsel = vs;
      write_en(en);
      check("R11 enable load", 32'(enables), 32'(en));
      irq_i = pat; step(); irq_i = '0;
      check("R2 flags latched with gie off", 32'(flags), 32'(pat));
      gie_set = 1; step();
      check("R9 gie set", 32'(gie), 1);
      instr_done = 1; step();
      check("R9 hold after set", 32'(vec_valid), 0);
      instr_done = 1; step();
      check("R5 valid", 32'(vec_valid), 1);
      check("R5 winner", 32'(vec_src), 32'(w));
      check("R6 address", 32'(vec_addr), 32'(exp_addr));
      check("R7 gie cleared", 32'(gie), 0);
      check("R7 winner flag cleared", 32'(flags), 32'(pat & ~(8'h1 << w)));
      int_ack = 1; step();
      check("R7 valid after ack", 32'(vec_valid), 0);
      clr_data = '1; clr_we = 1; step();
      check("R3 clear all", 32'(flags), 0);
    end
    vsel = 0;

    // R2: masked source with pending flag is not vectored while gie is 0
    do_reset();
    write_en(8'h04);
    irq_i = 8'h04; step(); irq_i = '0;
    instr_done = 1; step();
    instr_done = 1; step();
    check("R2 no vector with gie off", 32'(vec_valid), 0);
    check("R2 flag kept", 32'(flags), 32'h04);

    // R3: zero bits ignored; same-cycle event wins over clear
    clr_data = 8'h00; clr_we = 1; step();
    check("R3 zeros ignored", 32'(flags), 32'h04);
    clr_data = 8'h04; clr_we = 1; irq_i = 8'h04; step(); irq_i = '0;
    check("R3 event beats clear", 32'(flags), 32'h04);
    clr_data = 8'h04; clr_we = 1; step();
    check("R3 one clears", 32'(flags), 0);

    // R4: level source served from the line, no flag
    do_reset();
    write_en(8'h40);
    irq_i = 8'h40; step();
    check("R4 no flag for level", 32'(flags), 0);
    gie_set = 1; step();
    instr_done = 1; step();
    instr_done = 1; step();
    check("R4 level taken", 32'(vec_valid), 1);
    check("R4 level address", 32'(vec_addr), 14);
    int_ack = 1; step();
    irq_i = '0;
    // R4: pulse while disabled is forgotten
    write_en(8'h00);
    irq_i = 8'h80; step(); irq_i = '0; step();
    write_en(8'h80);
    gie_set = 1; step();
    instr_done = 1; step();
    instr_done = 1; step();
    check("R4 lost pulse not taken", 32'(vec_valid), 0);

    // R8: return sets gie with one-instruction hold
    do_reset();
    write_en(8'h01);
    irq_i = 8'h01; step(); irq_i = '0;
    reti = 1; step();
    check("R8 gie after reti", 32'(gie), 1);
    check("R8 no take at reti", 32'(vec_valid), 0);
    instr_done = 1; step();
    check("R8 hold one instruction", 32'(vec_valid), 0);
    instr_done = 1; step();
    check("R8 taken after hold", 32'(vec_valid), 1);
    check("R8 address", 32'(vec_addr), 2);
    int_ack = 1; step();

    // R10: disable blocks a simultaneous request
    do_reset();
    write_en(8'h40);
    gie_set = 1; step();
    instr_done = 1; step();
    irq_i = 8'h40; instr_done = 1; gie_clr = 1; step();
    check("R10 blocked", 32'(vec_valid), 0);
    check("R10 gie cleared", 32'(gie), 0);
    instr_done = 1; step();
    check("R10 stays blocked", 32'(vec_valid), 0);
    irq_i = '0;

    // R7: vector holds without acknowledge
    do_reset();
    write_en(8'h02);
    irq_i = 8'h02; step(); irq_i = '0;
    gie_set = 1; step();
    instr_done = 1; step();
    instr_done = 1; step();
    for (int k = 0; k < 3; k++) begin
      irq_i = 8'h01; instr_done = 1; step(); irq_i = '0;
    end
    check("R7 valid held", 32'(vec_valid), 1);
    check("R7 address held", 32'(vec_addr), 4);
    int_ack = 1; step();
    check("R7 released by ack", 32'(vec_valid), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule